// File: doc/BRIEF.md
# Power-Management Interrupt and Converter Register File

This block is the 16-bit register file of a power-management companion device. A host reaches it through a simple parallel port with a request strobe, a write enable and a 5-bit register index. It keeps an identification word, an interrupt status register whose bits are toggled by writes, an interrupt mask, a clock calibration word, a converter channel-select and result window, a sample-control word that writes can only clear, two general control words, a status word and a watchdog kick location.

Converter results do not come from a real converter. Each channel's 10-bit value is presented on an input bus, and the block returns the value of the selected channel. A level interrupt output combines unmasked status bits. A one-cycle shutdown request is raised when the watchdog is written with zero while the enabling control bit is set. A power-button input is edge-detected: each press or release posts an interrupt, and the status word shows whether the button is held. Indices that belong to functions outside this block read as zero and ignore writes. Unassigned indices also read as zero and flag an error.

Top module: `pmic_regfile`

## Requirements
- R1: Index 0x00 reads 0x0215 when VARIANT is 0 and 0x0295 when VARIANT is 1. Writes to it have no effect.
- R2: Index 0x01 reads the interrupt status. A write replaces the status with the status XOR the written value.
- R3: The mask at index 0x02 resets to 0xFFFF and is read/write. irq_o is high exactly when some status bit is 1 and its mask bit is 0. Status bit map: 0 button, 1 charger, 2 seconds, 3 minutes, 4 days, 5 alarm, 6 hook, 7 headset, 8 converter sample.
- R4: A read of index 0x08 returns the selected channel in bits [13:10] and that channel's 10-bit result in bits [9:0]. Bits [15:14] are 0. Channel k's result is adc_res_i[10k+9:10k].
- R5: A write to index 0x08 loads the channel from bits [13:10] of the written value and sets status bit 8.
- R6: The sample-control word at index 0x09 resets to SAMPLE_INIT (default 0x00FF). A write clears each bit that is 1 in the written value and never sets a bit.
- R7: The calibration word at index 0x06 resets to 0x0001. The control words at 0x0D and 0x0E reset to 0. All three are plain read/write.
- R8: A write of 0x0000 to index 0x17 while bit 1 of the 0x0D control word is 1 makes shutdown_o high for exactly the one cycle after the write. No other write raises it. Index 0x17 reads 0.
- R9: The status word at index 0x16 resets to 0x0020 and ignores writes. Its bit 5 is 0 while the button is pressed and 1 while it is released.
- R10: Each change of pwr_btn_i, whether a press or a release, sets status bit 0 once.
- R11: Indices 0x03–0x05, 0x0A–0x0C, 0x0F–0x11 and 0x18–0x1F read 0, ignore writes and do not raise err_o.
- R12: An access, read or write, to index 0x07 or 0x12–0x15 reads 0, changes no state and raises err_o for the one cycle after the access.
- R13: Read data appears on rdata_o in the cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Register index |
| wdata_i | input | 16 | Write data |
| adc_res_i | input | NCH*10 | Converter results, channel k at [10k+9:10k] |
| pwr_btn_i | input | 1 | Power button level, 1 = pressed (synchronous) |
| rdata_o | output | 16 | Read data, registered |
| err_o | output | 1 | Unassigned-index access pulse |
| irq_o | output | 1 | Level interrupt request |
| shutdown_o | output | 1 | Shutdown request pulse |

## Verification
On every cycle, the assertions check these properties:
- Toggling of the status register on writes to index 0x01.
- Setting of the sample bit by a channel write and of the button bit by a button edge.
- Silence of irq_o under a full mask.
- The fact that the sample-control word never gains a bit.
- The causes behind every shutdown and error pulse.

The bench scenarios cover what the assertions cannot. They confirm the read values of every index, the bit 5 level through a press and release cycle, the fixed identification word, and the fact that writes to out-of-scope and unassigned indices leave the state untouched.

// File: rtl/pmic_pkg.sv
package pmic_pkg;
  localparam int DW = 16;
  localparam int AW = 5;

  localparam logic [AW-1:0] A_ID     = 5'h00;
  localparam logic [AW-1:0] A_ISTAT  = 5'h01;
  localparam logic [AW-1:0] A_IMASK  = 5'h02;
  localparam logic [AW-1:0] A_CAL    = 5'h06;
  localparam logic [AW-1:0] A_ADC    = 5'h08;
  localparam logic [AW-1:0] A_SAMP   = 5'h09;
  localparam logic [AW-1:0] A_CTL1   = 5'h0D;
  localparam logic [AW-1:0] A_CTL2   = 5'h0E;
  localparam logic [AW-1:0] A_STATUS = 5'h16;
  localparam logic [AW-1:0] A_WDOG   = 5'h17;

  localparam int IRQ_BTN = 0;
  localparam int IRQ_ADC = 8;

  localparam logic [DW-1:0] ID_BASE     = 16'h0215;
  localparam logic [DW-1:0] CAL_RST     = 16'h0001;
  localparam logic [DW-1:0] STATUS_RST  = 16'h0020;
  localparam int            STATUS_BTN  = 5;
  localparam int            CTL1_WD_EN  = 1;
  localparam int            CH_LSB      = 10;
endpackage

// File: rtl/pmic_btn_edge.sv
module pmic_btn_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  output logic edge_o,
  output logic level_o
);
  logic btn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) btn_q <= 1'b0;
    else         btn_q <= btn_i;
  end

  assign edge_o  = btn_i ^ btn_q;
  assign level_o = btn_q;
endmodule

// File: rtl/pmic_irq_ctrl.sv
module pmic_irq_ctrl #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         xor_we_i,
  input  logic [W-1:0] xor_val_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_val_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  import pmic_pkg::*;

  logic [W-1:0] stat_q, mask_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (xor_we_i) stat_d = stat_d ^ xor_val_i;
    stat_d = stat_d | set_i;   // event sets win over a same-cycle toggle
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      stat_q <= stat_d;
      if (mask_we_i) mask_q <= mask_val_i;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = |(stat_q & ~mask_q);

  a_r2_xor_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xor_we_i && set_i == '0) |=> stat_q == ($past(stat_q) ^ $past(xor_val_i)));
  a_r3_full_mask_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_we_i && mask_val_i == '1) |=> !irq_o);
  a_r5_adc_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[IRQ_ADC] |=> stat_q[IRQ_ADC]);
  a_r10_btn_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[IRQ_BTN] |=> stat_q[IRQ_BTN]);
endmodule

// File: rtl/pmic_regfile.sv
module pmic_regfile #(
  parameter int              VARIANT     = 0,
  parameter int              NCH         = 16,
  parameter int              RES_W       = 10,
  parameter logic [15:0]     SAMPLE_INIT = 16'h00FF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [4:0]           addr_i,
  input  logic [15:0]          wdata_i,
  input  logic [NCH*RES_W-1:0] adc_res_i,
  input  logic                 pwr_btn_i,
  output logic [15:0]          rdata_o,
  output logic                 err_o,
  output logic                 irq_o,
  output logic                 shutdown_o
);
  import pmic_pkg::*;

  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [DW-1:0] ID_VAL = ID_BASE | ((VARIANT != 0) ? 16'h0080 : 16'h0000);

  logic [RES_W-1:0] res_arr [NCH];
  for (genvar k = 0; k < NCH; k++) begin : g_res
    assign res_arr[k] = adc_res_i[k*RES_W +: RES_W];
  end

  logic [DW-1:0] cal_q, ctl1_q, ctl2_q, samp_q, status_q, rdata_q;
  logic [CH_W-1:0] ch_q;
  logic err_q, sd_q;

  logic wr, rd, undef;
  logic [DW-1:0] rd_val, adc_view, stat, mask, set_vec;
  logic btn_edge, btn_level;

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  pmic_btn_edge i_btn (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .btn_i  (pwr_btn_i),
    .edge_o (btn_edge),
    .level_o(btn_level)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[IRQ_BTN] = btn_edge;
    set_vec[IRQ_ADC] = wr && (addr_i == A_ADC);
  end

  pmic_irq_ctrl #(.W(DW)) i_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .xor_we_i  (wr && addr_i == A_ISTAT),
    .xor_val_i (wdata_i),
    .mask_we_i (wr && addr_i == A_IMASK),
    .mask_val_i(wdata_i),
    .set_i     (set_vec),
    .stat_o    (stat),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );

  always_comb begin
    adc_view                   = '0;
    adc_view[CH_LSB +: CH_W]   = ch_q;
    adc_view[RES_W-1:0]        = res_arr[ch_q];
  end

  always_comb begin
    rd_val = '0;
    undef  = 1'b0;
    case (addr_i)
      A_ID:     rd_val = ID_VAL;
      A_ISTAT:  rd_val = stat;
      A_IMASK:  rd_val = mask;
      A_CAL:    rd_val = cal_q;
      A_ADC:    rd_val = adc_view;
      A_SAMP:   rd_val = samp_q;
      A_CTL1:   rd_val = ctl1_q;
      A_CTL2:   rd_val = ctl2_q;
      A_STATUS: rd_val = status_q;
      5'h07, 5'h12, 5'h13, 5'h14, 5'h15: undef = 1'b1;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_q    <= CAL_RST;
      ctl1_q   <= '0;
      ctl2_q   <= '0;
      samp_q   <= SAMPLE_INIT;
      status_q <= STATUS_RST;
      ch_q     <= '0;
      rdata_q  <= '0;
      err_q    <= 1'b0;
      sd_q     <= 1'b0;
    end else begin
      if (wr && addr_i == A_CAL)  cal_q  <= wdata_i;
      if (wr && addr_i == A_CTL1) ctl1_q <= wdata_i;
      if (wr && addr_i == A_CTL2) ctl2_q <= wdata_i;
      if (wr && addr_i == A_SAMP) samp_q <= samp_q & ~wdata_i;
      if (wr && addr_i == A_ADC)  ch_q   <= wdata_i[CH_LSB +: CH_W];
      if (btn_edge) status_q[STATUS_BTN] <= ~pwr_btn_i;
      if (rd) rdata_q <= rd_val;
      err_q <= req_i && undef;
      sd_q  <= wr && (addr_i == A_WDOG) && (wdata_i == '0) && ctl1_q[CTL1_WD_EN];
    end
  end

  assign rdata_o    = rdata_q;
  assign err_o      = err_q;
  assign shutdown_o = sd_q;

  a_r6_samp_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (samp_q & ~$past(samp_q)) == '0);
  a_r8_sd_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> ($past(wr) && $past(addr_i) == A_WDOG && $past(wdata_i) == '0));
  a_r12_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($past(req_i) && ($past(addr_i) == 5'h07 ||
              ($past(addr_i) >= 5'h12 && $past(addr_i) <= 5'h15))));
  a_r9_status_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    btn_edge |=> status_q[STATUS_BTN] == !btn_level);
endmodule

// File: tb/test_pmic_regfile.sv
module test_pmic_regfile;
  localparam int NCH = 16;
  localparam int RW  = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, btn = 1'b0;
  logic [4:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [NCH*RW-1:0] adc;
  logic [15:0] rdata;
  logic err, irq, sd;

  int n_chk = 0, n_fail = 0;

  logic [15:0] m_stat, m_mask, m_cal, m_ctl1, m_ctl2, m_samp, m_status;
  logic [3:0]  m_ch;
  logic        m_btn;
  logic [9:0]  res [NCH];

  always #4 clk = ~clk;

  pmic_regfile i_pmic_regfile (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .adc_res_i(adc), .pwr_btn_i(btn), .rdata_o(rdata),
    .err_o(err), .irq_o(irq), .shutdown_o(sd)
  );

  task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic is_undef(input logic [4:0] a);
    return a == 5'h07 || (a >= 5'h12 && a <= 5'h15);
  endfunction

  function automatic logic [15:0] exp_rd(input logic [4:0] a);
    case (a)
      5'h00: return 16'h0215;
      5'h01: return m_stat;
      5'h02: return m_mask;
      5'h06: return m_cal;
      5'h08: return {2'b00, m_ch, res[m_ch]};
      5'h09: return m_samp;
      5'h0D: return m_ctl1;
      5'h0E: return m_ctl2;
      5'h16: return m_status;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string tag(input logic [4:0] a);
    case (a)
      5'h00: return "R1";
      5'h01: return "R2";
      5'h02: return "R3";
      5'h08: return "R4";
      5'h09: return "R6";
      5'h06, 5'h0D, 5'h0E: return "R7";
      5'h17: return "R8";
      5'h16: return "R9";
      default: return is_undef(a) ? "R12" : "R11";
    endcase
  endfunction

  task automatic chk_irq();
    chk("R3 irq", {15'd0, irq}, {15'd0, |(m_stat & ~m_mask)});
  endtask

  task automatic do_wr(input logic [4:0] a, input logic [15:0] d);
    logic exp_sd;
    exp_sd = (a == 5'h17) && (d == 16'h0) && m_ctl1[1];
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    case (a)
      5'h01: m_stat = m_stat ^ d;
      5'h02: m_mask = d;
      5'h06: m_cal  = d;
      5'h08: begin m_ch = d[13:10]; m_stat[8] = 1'b1; end
      5'h09: m_samp = m_samp & ~d;
      5'h0D: m_ctl1 = d;
      5'h0E: m_ctl2 = d;
      default: ;
    endcase
    chk("R12 err after write", {15'd0, err}, {15'd0, is_undef(a)});
    chk("R8 shutdown", {15'd0, sd}, {15'd0, exp_sd});
    chk_irq();
  endtask

  task automatic do_rd(input logic [4:0] a);
    logic [15:0] e;
    e = exp_rd(a);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    chk({tag(a), " read (R13)"}, rdata, e);
    chk("R12 err after read", {15'd0, err}, {15'd0, is_undef(a)});
    chk("R8 no shutdown on read", {15'd0, sd}, 16'd0);
  endtask

  task automatic set_btn(input logic v);
    @(negedge clk);
    btn = v;
    @(negedge clk);
    if (v != m_btn) begin
      m_stat[0] = 1'b1;
      m_status[5] = ~v;
      m_btn = v;
    end
    chk_irq();
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < NCH; k++) begin
      res[k] = 10'($urandom);
      adc[k*RW +: RW] = res[k];
    end
    m_stat = 16'h0; m_mask = 16'hFFFF; m_cal = 16'h0001; m_ctl1 = 16'h0;
    m_ctl2 = 16'h0; m_samp = 16'h00FF; m_status = 16'h0020; m_ch = 4'h0; m_btn = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    chk("R3 irq at reset", {15'd0, irq}, 16'd0);
    chk("R8 shutdown at reset", {15'd0, sd}, 16'd0);
    do_rd(5'h00); do_rd(5'h02); do_rd(5'h06); do_rd(5'h09); do_rd(5'h16); do_rd(5'h08);

    // R1 write ignored
    do_wr(5'h00, 16'hFFFF); do_rd(5'h00);
    // R2 toggle
    do_wr(5'h01, 16'h00A5); do_rd(5'h01);
    do_wr(5'h01, 16'h0005); do_rd(5'h01);
    // R3 unmask
    do_wr(5'h02, 16'hFF5F); do_rd(5'h02);
    do_wr(5'h02, 16'hFFFF);
    do_wr(5'h01, m_stat);
    // R4 R5 channel select
    do_wr(5'h08, 16'h3C00); do_rd(5'h08); do_rd(5'h01);
    do_wr(5'h08, 16'h1400); do_rd(5'h08);
    do_wr(5'h02, 16'hFEFF);
    do_rd(5'h01);
    // R6 clear-only
    do_wr(5'h09, 16'hFF0F); do_rd(5'h09);
    // R7
    do_wr(5'h06, 16'h1234); do_wr(5'h0E, 16'hBEEF); do_rd(5'h06); do_rd(5'h0E);
    // R8 watchdog
    do_wr(5'h0D, 16'h0000); do_wr(5'h17, 16'h0000);
    do_wr(5'h0D, 16'h0002); do_wr(5'h17, 16'h0001); do_wr(5'h17, 16'h0000);
    do_rd(5'h17);
    // R9 R10 button
    do_wr(5'h02, 16'hFFFE);
    do_wr(5'h01, m_stat);
    set_btn(1'b1); do_rd(5'h16); do_rd(5'h01);
    do_wr(5'h01, 16'h0001);
    set_btn(1'b1); do_rd(5'h01);
    set_btn(1'b0); do_rd(5'h16); do_rd(5'h01);
    do_wr(5'h16, 16'h0000); do_rd(5'h16);
    // R11 R12 ignored writes
    do_wr(5'h0A, 16'hFFFF); do_rd(5'h0A); do_rd(5'h0D);
    do_wr(5'h07, 16'hFFFF); do_rd(5'h07); do_rd(5'h01);
    do_wr(5'h13, 16'h5555); do_rd(5'h15); do_rd(5'h1F);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [4:0] a;
      logic [15:0] d;
      a = 5'($urandom);
      d = ($urandom % 8 == 0) ? 16'h0 : 16'($urandom);
      case ($urandom % 6)
        0: set_btn(1'($urandom));
        1, 2: do_rd(a);
        default: do_wr(a, d);
      endcase
    end
    for (int a = 0; a < 32; a++) do_rd(5'(a));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule